// File: doc/BRIEF.md
# Timer Match-Output and Capture Unit

This block sits beside a free-running timer counter and turns counter values into output events. It has a set of match channels, four by default. Each channel compares the counter with its own match value. When a new counter value equals that match value, the channel applies a programmed action to its own output state bit. The action is one of: keep, force low, force high or invert. Software can read each state bit and overwrite it through a combined match-output register. That register also holds the per-channel action fields.

A single capture channel watches an input that may be asynchronous. It resynchronises the input and looks for a high-to-low transition. When that detection is enabled, it copies the counter into a capture register. A separate enable makes each such copy set a sticky interrupt flag, which software clears with a write-one pulse. A build parameter removes the capture channel entirely. The counter, its prescaler, PWM behaviour and the bus fabric are outside the block. The counter value arrives as an input, and the match values arrive as a flat input vector.

Top module: `tmr_match_cap`

## Requirements
- R1: After reset, every output state bit, every action field, both capture control bits, the capture register and the interrupt are zero.
- R2: The match-output register holds the state of channel n at bit n. The 2-bit action field of channel n sits at bits [NCH+2n+1 : NCH+2n], which is [5:4], [7:6], [9:8] and [11:10] for four channels. A write stores both, and a read returns the current state and the stored fields. Output pin n always equals state bit n.
- R3: Action codes are 00 = keep, 01 = force low, 10 = force high, 11 = invert. A channel whose match value equals the counter applies its action on that same rising edge, so the result is visible in the following cycle.
- R4: A match fires only in a cycle where the counter differs from its value in the previous cycle, or in the first cycle after reset. A counter held at the match value acts once.
- R5: A software write to the match-output register in the same cycle as a match action wins: the state bit takes the written value.
- R6: Each channel acts only on its own match value and its own action field.
- R7: With falling-capture enabled (capture-control bit 0), a 1 then 0 on the capture input loads the capture register. The input goes through two synchroniser flops. The load happens on the third rising edge after the input falls, and it stores the counter value present in the cycle just before that edge.
- R8: A rising transition on the capture input, or a falling one while capture-control bit 0 is clear, leaves the capture register unchanged.
- R9: With the interrupt enable set (capture-control bit 1), each capture load sets the interrupt on the same edge. With the enable clear, a load does not set it. Once set, the interrupt stays set until it is cleared.
- R10: A one-cycle pulse on the clear input clears the interrupt. If a capture load with the interrupt enabled happens in the same cycle, the set wins.
- R11: With the capture parameter off, the capture control bits read as zero, and the capture register and the interrupt stay zero whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Timer counter value |
| match_vals_i | input | NCH*CW | Match values, channel n at bits [n*CW +: CW] |
| ext_wr_i | input | 1 | Write strobe for the match-output register |
| ext_wdata_i | input | 3*NCH | Write data for the match-output register |
| ext_rdata_o | output | 3*NCH | Read data of the match-output register |
| mat_o | output | NCH | Match output pins |
| cap_ctl_wr_i | input | 1 | Write strobe for the capture control bits |
| cap_ctl_wdata_i | input | 2 | Bit 0 falling-capture enable, bit 1 interrupt enable |
| cap_ctl_rdata_o | output | 2 | Current capture control bits |
| irq_clr_i | input | 1 | Write-one pulse that clears the interrupt |
| cap_in_i | input | 1 | Capture input, may be asynchronous |
| cap_val_o | output | CW | Capture register |
| irq_o | output | 1 | Sticky capture interrupt |

## Verification
The assertions assume a few things about the inputs. The counter, the match values and all write and clear strobes change only just after a rising clock edge and stay stable for the whole cycle. The capture input holds each level long enough to pass through the synchroniser. The bench drives every input one nanosecond after a rising edge and samples the outputs at the same offset. It holds each capture level for at least three cycles, and it asserts write and clear strobes for exactly one cycle. That keeps every property's antecedent in the cycle where the design actually samples it.

// File: rtl/tmr_match_cap_pkg.sv
package tmr_match_cap_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } match_act_e;

  localparam int unsigned CAP_CTL_W = 2;
  localparam int unsigned CTL_FALL  = 0;
  localparam int unsigned CTL_IE    = 1;

endpackage

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_match_cap_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] match_i,
  input  logic          cnt_new_i,
  input  logic          wr_i,
  input  logic          wr_em_i,
  input  logic [1:0]    wr_act_i,
  output logic          em_o,
  output logic [1:0]    act_o
);

  logic       em_q, em_d;
  match_act_e act_q;
  logic       hit;

  assign hit = cnt_new_i && (cnt_i == match_i);

  always_comb begin
    em_d = em_q;
    if (wr_i) begin
      em_d = wr_em_i;
    end else if (hit) begin
      unique case (act_q)
        ACT_LOW:    em_d = 1'b0;
        ACT_HIGH:   em_d = 1'b1;
        ACT_TOGGLE: em_d = ~em_q;
        default:    em_d = em_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      em_q  <= 1'b0;
      act_q <= ACT_KEEP;
    end else begin
      em_q <= em_d;
      if (wr_i) act_q <= match_act_e'(wr_act_i);
    end
  end

  assign em_o  = em_q;
  assign act_o = act_q;

  // R5
  sw_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> em_q == $past(wr_em_i));

  // R3
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && hit && act_q == ACT_LOW) |=> !em_q);

  // R3
  force_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && hit && act_q == ACT_HIGH) |=> em_q);

  // R3
  invert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && hit && act_q == ACT_TOGGLE) |=> em_q != $past(em_q));

  // R4
  held_count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !cnt_new_i) |=> $stable(em_q));

  // R6
  no_hit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && cnt_i != match_i) |=> $stable(em_q));

endmodule

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic fall_o
);

  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], din_i};
  end

  assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

  // R7
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_cap_unit.sv
module tmr_cap_unit
  import tmr_match_cap_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        cnt_i,
  input  logic                 fall_i,
  input  logic                 ctl_wr_i,
  input  logic [CAP_CTL_W-1:0] ctl_wdata_i,
  input  logic                 irq_clr_i,
  output logic [CAP_CTL_W-1:0] ctl_o,
  output logic [CW-1:0]        cap_o,
  output logic                 irq_o
);

  logic [CAP_CTL_W-1:0] ctl_q;
  logic [CW-1:0]        cap_q;
  logic                 flag_q, flag_d;
  logic                 load, irq_set;

  assign load    = fall_i && ctl_q[CTL_FALL];
  assign irq_set = load && ctl_q[CTL_IE];

  always_comb begin
    flag_d = flag_q;
    if (irq_set)        flag_d = 1'b1;
    else if (irq_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_wr_i) ctl_q <= ctl_wdata_i;
      if (load)     cap_q <= cnt_i;
      flag_q <= flag_d;
    end
  end

  assign ctl_o = ctl_q;
  assign cap_o = cap_q;
  assign irq_o = flag_q;

  // R7
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && ctl_q[CTL_FALL]) |=> cap_q == $past(cnt_i));

  // R8
  no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_i && ctl_q[CTL_FALL]) |=> $stable(cap_q));

  // R9
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && ctl_q[CTL_FALL] && ctl_q[CTL_IE]) |=> irq_o);

  // R10
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !(fall_i && ctl_q[CTL_FALL] && ctl_q[CTL_IE])) |=> !irq_o);

  // R9
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_clr_i && !(fall_i && ctl_q[CTL_FALL] && ctl_q[CTL_IE])) |=> $stable(irq_o));

endmodule

// File: rtl/tmr_match_cap.sv
module tmr_match_cap
  import tmr_match_cap_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NCH    = 4,
  parameter bit CAP_EN = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        cnt_i,
  input  logic [NCH*CW-1:0]    match_vals_i,
  input  logic                 ext_wr_i,
  input  logic [3*NCH-1:0]     ext_wdata_i,
  output logic [3*NCH-1:0]     ext_rdata_o,
  output logic [NCH-1:0]       mat_o,
  input  logic                 cap_ctl_wr_i,
  input  logic [CAP_CTL_W-1:0] cap_ctl_wdata_i,
  output logic [CAP_CTL_W-1:0] cap_ctl_rdata_o,
  input  logic                 irq_clr_i,
  input  logic                 cap_in_i,
  output logic [CW-1:0]        cap_val_o,
  output logic                 irq_o
);

  localparam int ACT_LSB  = NCH;
  localparam int RST_STGS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STGS-1:0] rst_sh_q;
  logic                rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sh_q <= '0;
    else         rst_sh_q <= {rst_sh_q[RST_STGS-2:0], 1'b1};
  end
  assign rst_n = rst_sh_q[RST_STGS-1];

  // new-count detection shared by all channels
  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          cnt_new;

  assign cnt_new = !seen_q || (cnt_i != cnt_q);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_i;
      seen_q <= 1'b1;
    end
  end

  // match channels
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [1:0] act;

    tmr_match_chan #(.CW(CW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .cnt_i     (cnt_i),
      .match_i   (match_vals_i[n*CW +: CW]),
      .cnt_new_i (cnt_new),
      .wr_i      (ext_wr_i),
      .wr_em_i   (ext_wdata_i[n]),
      .wr_act_i  (ext_wdata_i[ACT_LSB + 2*n +: 2]),
      .em_o      (mat_o[n]),
      .act_o     (act)
    );

    assign ext_rdata_o[n]                 = mat_o[n];
    assign ext_rdata_o[ACT_LSB + 2*n +: 2] = act;
  end

  // capture channel
  if (CAP_EN) begin : g_cap
    logic fall;

    tmr_cap_edge #(.SYNC_STAGES(2)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .din_i  (cap_in_i),
      .fall_o (fall)
    );

    tmr_cap_unit #(.CW(CW)) u_cap (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .cnt_i       (cnt_i),
      .fall_i      (fall),
      .ctl_wr_i    (cap_ctl_wr_i),
      .ctl_wdata_i (cap_ctl_wdata_i),
      .irq_clr_i   (irq_clr_i),
      .ctl_o       (cap_ctl_rdata_o),
      .cap_o       (cap_val_o),
      .irq_o       (irq_o)
    );
  end else begin : g_nocap
    assign cap_ctl_rdata_o = '0;
    assign cap_val_o       = '0;
    assign irq_o           = 1'b0;

    // R11
    nocap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cap_ctl_wr_i || !cap_in_i) |=> (cap_val_o == '0) && !irq_o);
  end

  // R2
  pin_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ext_wr_i |=> mat_o == $past(ext_wdata_i[NCH-1:0]));

endmodule

// File: tb/tmr_match_cap_tb.sv
`timescale 1ns/1ps
module tmr_match_cap_tb;

  localparam int CW  = 32;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CW-1:0]     cnt;
  logic [NCH*CW-1:0] mvals;
  logic              ext_wr;
  logic [3*NCH-1:0]  ext_wdata;
  logic [3*NCH-1:0]  ext_rdata, ext_rdata_nc;
  logic [NCH-1:0]    mat, mat_nc;
  logic              cc_wr;
  logic [1:0]        cc_wdata, cc_rdata, cc_rdata_nc;
  logic              clr;
  logic              cap_in;
  logic [CW-1:0]     cap_val, cap_val_nc;
  logic              irq, irq_nc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_match_cap #(.CW(CW), .NCH(NCH), .CAP_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .match_vals_i(mvals),
    .ext_wr_i(ext_wr), .ext_wdata_i(ext_wdata), .ext_rdata_o(ext_rdata),
    .mat_o(mat), .cap_ctl_wr_i(cc_wr), .cap_ctl_wdata_i(cc_wdata),
    .cap_ctl_rdata_o(cc_rdata), .irq_clr_i(clr), .cap_in_i(cap_in),
    .cap_val_o(cap_val), .irq_o(irq)
  );

  tmr_match_cap #(.CW(CW), .NCH(NCH), .CAP_EN(1'b0)) u_dut_nocap (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .match_vals_i(mvals),
    .ext_wr_i(ext_wr), .ext_wdata_i(ext_wdata), .ext_rdata_o(ext_rdata_nc),
    .mat_o(mat_nc), .cap_ctl_wr_i(cc_wr), .cap_ctl_wdata_i(cc_wdata),
    .cap_ctl_rdata_o(cc_rdata_nc), .irq_clr_i(clr), .cap_in_i(cap_in),
    .cap_val_o(cap_val_nc), .irq_o(irq_nc)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ext_write(logic [3*NCH-1:0] v);
    ext_wr = 1'b1; ext_wdata = v;
    tick();
    ext_wr = 1'b0;
  endtask

  task automatic ctl_write(logic [1:0] v);
    cc_wr = 1'b1; cc_wdata = v;
    tick();
    cc_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mat", {28'd0, mat}, 32'h0);
    chk("R1 ext reg", {20'd0, ext_rdata}, 32'h0);
    chk("R1 cap ctl", {30'd0, cc_rdata}, 32'h0);
    chk("R1 cap val", cap_val, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_reg_layout();
    ext_write(12'h0F5);
    chk("R2 readback", {20'd0, ext_rdata}, 32'h0F5);
    chk("R2 pins", {28'd0, mat}, 32'h5);
  endtask

  // ch0 keep, ch1 low, ch2 high, ch3 invert; states start 0011
  task automatic t_actions();
    ext_write(12'hE43);
    cnt = 10; tick(); chk("R3 keep ch0", {28'd0, mat}, 32'h3);
    cnt = 20; tick(); chk("R3 low ch1 R6", {28'd0, mat}, 32'h1);
    cnt = 30; tick(); chk("R3 high ch2 R6", {28'd0, mat}, 32'h5);
    cnt = 40; tick(); chk("R3 invert ch3", {28'd0, mat}, 32'hD);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R4 held count", {28'd0, mat}, 32'hD);
    end
    cnt = 41; tick(); chk("R6 no match", {28'd0, mat}, 32'hD);
    cnt = 40; tick(); chk("R4 new value inverts again", {28'd0, mat}, 32'h5);
  endtask

  task automatic t_priority();
    cnt = 41; tick();
    cnt = 40;
    ext_write(12'hE42);
    chk("R5 write wins", {28'd0, mat}, 32'h2);
    chk("R5 readback", {20'd0, ext_rdata}, 32'hE42);
    tick(); chk("R4 held after write", {28'd0, mat}, 32'h2);
  endtask

  // drives a fall and returns after the load edge; checks no early load
  task automatic fall_seq(logic [31:0] base, logic [31:0] old_val, logic clr_last);
    cap_in = 1'b0; cnt = base; tick();
    cnt = base + 1; tick();
    chk("R7 no early load", cap_val, old_val);
    cnt = base + 2; clr = clr_last; tick();
    clr = 1'b0;
  endtask

  task automatic t_capture();
    ctl_write(2'b01);
    chk("R11 nocap ctl reads zero", {30'd0, cc_rdata_nc}, 32'h0);
    chk("R7 ctl readback", {30'd0, cc_rdata}, 32'h1);
    cap_in = 1'b1; repeat (4) tick();
    fall_seq(100, 0, 1'b0);
    chk("R7 captured", cap_val, 32'd102);
    chk("R9 no irq with enable clear", {31'd0, irq}, 32'h0);
    // rising edge
    cnt = 200; cap_in = 1'b1;
    for (int i = 0; i < 4; i++) begin cnt = cnt + 1; tick(); end
    chk("R8 rising ignored", cap_val, 32'd102);
    // falling with capture disabled
    ctl_write(2'b00);
    cap_in = 1'b0; cnt = 300;
    for (int i = 0; i < 4; i++) begin cnt = cnt + 1; tick(); end
    chk("R8 disabled ignored", cap_val, 32'd102);
    chk("R11 nocap stays zero", cap_val_nc, 32'h0);
    chk("R11 nocap irq", {31'd0, irq_nc}, 32'h0);
  endtask

  task automatic t_irq();
    ctl_write(2'b11);
    cap_in = 1'b1; repeat (4) tick();
    fall_seq(500, 102, 1'b0);
    chk("R7 captured 2", cap_val, 32'd502);
    chk("R9 irq set", {31'd0, irq}, 32'h1);
    repeat (3) tick();
    chk("R9 irq sticky", {31'd0, irq}, 32'h1);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R10 irq cleared", {31'd0, irq}, 32'h0);
    // collision: clear in the load cycle
    cap_in = 1'b1; repeat (4) tick();
    fall_seq(600, 502, 1'b1);
    chk("R10 set beats clear", {31'd0, irq}, 32'h1);
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R10 cleared again", {31'd0, irq}, 32'h0);
    // enable clear: load without interrupt
    ctl_write(2'b01);
    cap_in = 1'b1; repeat (4) tick();
    fall_seq(700, 602, 1'b0);
    chk("R7 captured 3", cap_val, 32'd702);
    chk("R9 no irq when disabled", {31'd0, irq}, 32'h0);
    chk("R11 nocap irq end", {31'd0, irq_nc}, 32'h0);
    chk("R11 nocap val end", cap_val_nc, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; cnt = '0; ext_wr = 1'b0; ext_wdata = '0;
    cc_wr = 1'b0; cc_wdata = '0; clr = 1'b0; cap_in = 1'b1;
    mvals = {32'd40, 32'd30, 32'd20, 32'd10};
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();
    t_reset();
    t_reg_layout();
    t_actions();
    t_priority();
    t_capture();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule